// File: doc/BRIEF.md
# Transmit Power Ramp Controller

This block shapes the envelope of a transmit burst. It holds an 11-bit ramp control value that represents the burst amplitude, where a full-scale count of 2047 stands for 1.0. While the host requests ramp-up, each update tick raises the value by a programmable 9-bit step until it reaches the programmed gain level. When the request drops, each tick lowers the value by a separately programmed 9-bit step until it reaches zero.

The ramp control value drives the amplitude output in one of two ways. In linear mode it drives the output directly. In sigmoid mode its top six bits index a 64-entry S-curve table. A sticky flag reports that the ramp-down has finished.

The tick is generated outside the block. At 32 ticks per symbol, step sizes from 511 down to 1 cover ramp durations from about 0.125 to 64 symbol times.

Top module: `tx_ramp_ctrl`

## Requirements
- R1: After reset the ramp value is 0, `amp` is 0 and `dn_done` is 0.
- R2: On a clock edge with `tick`=1 and `ramp_up`=1, the ramp value becomes `min(value + up_inc, gain_lvl)`. If the value is already at or above `gain_lvl`, it becomes `gain_lvl`.
- R3: After any ramp-up tick, the ramp value never exceeds `gain_lvl`, and it never exceeds 2047.
- R4: On a clock edge with `tick`=1 and `ramp_up`=0, the ramp value becomes 0 if it is less than or equal to `dn_dec`. Otherwise it becomes `value - dn_dec`.
- R5: On edges with `tick`=0, the ramp value and `dn_done` keep their values, whatever `ramp_up`, `up_inc`, `dn_dec` and `gain_lvl` do.
- R6: With `nonlin`=0, `amp` equals the ramp value combinationally.
- R7: With `nonlin`=1, `amp` equals `floor(k*k*(189-2k)*2047/250047)`, where k is bits 10:5 of the ramp value. This gives 0 at k=0 and 2047 at k=63, and is monotonic in between.
- R8: `dn_done` sets on a ramp-down tick whose result is 0, and clears on a ramp-up tick. While `dn_done` is 1, the ramp value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Ramp update strobe |
| ramp_up | input | 1 | 1 = ramp up toward gain, 0 = ramp down toward zero |
| up_inc | input | 9 | Up step size |
| dn_dec | input | 9 | Down step size |
| gain_lvl | input | 11 | Ramp-up ceiling |
| nonlin | input | 1 | 0 = linear amplitude, 1 = sigmoid amplitude |
| amp | output | 11 | Envelope amplitude |
| dn_done | output | 1 | Ramp-down complete flag |

## Verification
The bench runs full bursts in both mapping modes, over step sizes that do and do not divide the gain evenly, including steps of 0 and 511 and gains of 0 and 2047. It checks every tick against an arithmetic model.

The key corner is the last step before the ceiling or the floor. A design that overshoots `gain_lvl`, wraps below zero, or stops one step short shows a wrong amplitude at that tick. Both mapping modes visit every table index, so a table with a wrong curve or a wrong index slice differs at some entry. Idle cycles with the inputs changing would expose a design that updates without a tick. Checking the flag around the first up tick would catch a flag that never clears or sets too early.

// File: rtl/tx_ramp_ctrl.sv
module tx_ramp_ctrl #(
  parameter int W      = 11,
  parameter int STEP_W = 9,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ramp_up,
  input  logic [STEP_W-1:0] up_inc,
  input  logic [STEP_W-1:0] dn_dec,
  input  logic [W-1:0]      gain_lvl,
  input  logic              nonlin,
  output logic [W-1:0]      amp,
  output logic              dn_done
);
  localparam int SW = W + 1;
  localparam int N = 1 << IDX_W;
  localparam longint unsigned FULL = (64'd1 << W) - 1;
  localparam longint unsigned M = N - 1;

  logic [W-1:0] rcr;
  logic [W-1:0] lut [N];

  wire [SW-1:0] up_sum  = {1'b0, rcr} + SW'(up_inc);
  wire [W-1:0]  up_next = (up_sum >= {1'b0, gain_lvl}) ? gain_lvl : up_sum[W-1:0];
  wire          dn_zero = rcr <= W'(dn_dec);
  wire [W-1:0]  dn_next = dn_zero ? '0 : rcr - W'(dn_dec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcr     <= '0;
      dn_done <= 1'b0;
    end else if (tick) begin
      rcr     <= ramp_up ? up_next : dn_next;
      dn_done <= ramp_up ? 1'b0 : dn_zero;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_lut
    localparam longint unsigned K = g;
    localparam longint unsigned NUM = K * K * (3 * M - 2 * K);
    assign lut[g] = W'(NUM * FULL / (M * M * M));
  end

  assign amp = nonlin ? lut[rcr[W-1 -: IDX_W]] : rcr;

  a_r3_under_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ramp_up) |=> amp <= $past(gain_lvl) || nonlin)
    else $error("R3 ramp above gain");
  a_r4_down_mono: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ramp_up) |=> rcr <= $past(rcr))
    else $error("R4 ramp rose on down tick");
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(rcr) && $stable(dn_done))
    else $error("R5 change without tick");
  a_r8_done_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dn_done |-> rcr == '0)
    else $error("R8 done with nonzero ramp");
  a_r8_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ramp_up) |=> !dn_done)
    else $error("R8 done not cleared");
endmodule

// File: tb/tb_tx_ramp_ctrl.sv
module tb_tx_ramp_ctrl;
  logic clk = 0, rst_n = 0, tick = 0, ramp_up = 0, nonlin = 0;
  logic [8:0] up_inc = 0, dn_dec = 0;
  logic [10:0] gain_lvl = 0;
  logic [10:0] amp;
  logic dn_done;
  int tests = 0, fails = 0;
  int model = 0;
  bit mdone = 0;

  always #2 clk = ~clk;

  tx_ramp_ctrl dut (.clk, .rst_n, .tick, .ramp_up, .up_inc, .dn_dec,
                    .gain_lvl, .nonlin, .amp, .dn_done);

  function automatic int exp_amp(int v, bit nl);
    longint k;
    if (!nl) return v;
    k = v >> 5;
    return int'(k * k * (189 - 2 * k) * 2047 / 250047);
  endfunction

  task automatic check(string req);
    int e = exp_amp(model, nonlin);
    tests++;
    if (amp !== 11'(e) || dn_done !== mdone) begin
      fails++;
      $display("FAIL %s amp=%0d exp=%0d done=%0b exp=%0b", req, amp, e, dn_done, mdone);
    end
  endtask

  task automatic step(bit up);
    @(negedge clk);
    ramp_up = up; tick = 1;
    @(negedge clk);
    tick = 0;
    if (up) begin
      model = (model + up_inc >= gain_lvl) ? gain_lvl : model + up_inc;
      mdone = 0;
    end else begin
      model = (model <= dn_dec) ? 0 : model - dn_dec;
      mdone = (model == 0);
    end
    #1;
  endtask

  task automatic burst(int inc, int dec, int g, bit nl, string rup);
    up_inc = 9'(inc); dn_dec = 9'(dec); gain_lvl = 11'(g); nonlin = nl;
    for (int i = 0; i < 2100 && !(model == g && i > 0); i++) begin
      step(1); check(rup);
      if (inc == 0) break;
    end
    step(1); check("R3");
    for (int i = 0; i < 2100 && !(mdone && i > 0); i++) begin
      step(0); check("R4");
    end
    check("R8");
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
      end
      begin
        repeat (3) @(negedge clk);
        #1; check("R1");
        rst_n = 1;
        @(negedge clk); #1; check("R1");
        burst(1, 1, 2047, 0, "R2 R6");
        burst(1, 3, 2047, 1, "R2 R7");
        burst(511, 511, 2047, 0, "R2");
        burst(100, 37, 1500, 1, "R7");
        burst(7, 200, 999, 0, "R2");
        burst(0, 5, 500, 0, "R2");
        burst(300, 0, 0, 0, "R3");
        burst(64, 64, 1024, 1, "R7");
        up_inc = 50; gain_lvl = 800; nonlin = 0;
        for (int i = 0; i < 6; i++) begin step(1); check("R2"); end
        gain_lvl = 120;
        step(1); check("R3 lowered gain");
        for (int i = 0; i < 20; i++) begin
          @(negedge clk);
          ramp_up = i[0]; up_inc = 9'(i * 25); dn_dec = 9'(i * 13);
          gain_lvl = 11'(i * 100); nonlin = i[1];
          #1; check("R5 no tick");
        end
        nonlin = 0; dn_dec = 9'd1;
        step(0); check("R4");
        step(0); check("R8 not done yet");
        dn_dec = 9'd511;
        step(0); check("R8 done");
        step(0); check("R8 stays");
        up_inc = 9'd3; gain_lvl = 11'd2047;
        step(1); check("R8 clear");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule